// File: doc/BRIEF.md
# Outbound Post-List Index Tracker

This block keeps the two indices of a circular reply list that lives in host memory. A local processor fills list entries with reply frame addresses. Each time it posts an entry, it advances a producer index by writing to an increment register. The host drains entries and writes back a consumer index once it has serviced them. When the producer index reaches the last entry of the configured list, it wraps to zero.

A cycle-indicator bit accompanies the producer side. It starts at 1 and flips on every wrap, so the host can tell which pass through the list an entry belongs to. The block merges this bit into the frame address that is to be posted. Frames are 16-byte aligned, so the low four address bits are free: bits [3:1] are forced to zero and bit 0 carries the cycle bit.

A sticky interrupt status bit reports a non-empty list. It is set while the extended mode is enabled and the two indices differ, and it is cleared by a write-one-to-clear access. All registers sit behind one small word-addressed write port with a combinational read port.

Top module: `post_list_tracker`

## Requirements
- R1: After reset, the producer index and the consumer index are 0, the cycle bit is 1, the enable bit is 0 and the interrupt status is 0.
- R2: `xmfa_out` equals `frame_addr` with bits [3:1] forced to 0 and bit 0 replaced by the current cycle bit.
- R3: Register 0 holds the enable bit at bit 0 and the size code at bits [6:4]. The list has 2^(code+4) entries, and register 0 reads back as {25'b0, code, 3'b0, enable}.
- R4: Any write to register 2, whatever its data, advances the producer index by one on the next clock edge if the index is below the last entry. The cycle bit is unchanged.
- R5: A write to register 2 while the producer index is at or beyond the last entry (entries-1) sets the index to 0 and toggles the cycle bit in the same clock edge.
- R6: A write to register 1 loads the producer index with the write data ANDed with entries-1 and sets the cycle bit to 1, with no increment. Register 1 reads as {cycle, 20'b0, producer index}.
- R7: A write to register 3 loads the consumer index with the write data ANDed with entries-1 and leaves the producer index unchanged. Register 3 reads as {21'b0, consumer index}. Register 2 reads as 0.
- R8: The interrupt status (`irq` and bit 0 of register 4) sets on the clock edge after a cycle in which the enable bit is 1 and the indices differ. It then stays set after the indices become equal.
- R9: A write to register 4 with bit 0 set clears the status, and the clear wins over a set in that cycle. If the enable bit is 1 and the indices still differ, the status sets again one edge later. A write to register 4 with bit 0 clear has no effect.
- R10: While the enable bit is 0, a clear status stays clear, whatever the indices hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (0..4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| frame_addr | input | ADDR_W | Aligned reply frame address to be posted |
| xmfa_out | output | ADDR_W | Frame address with the cycle bit merged in |
| irq | output | 1 | Sticky non-empty interrupt status |

## Verification
Two events can fall in the same cycle: the host's write-one-to-clear of the status and the set condition of indices that still differ. The bench advances the producer past the consumer with the enable bit on and waits for the status to set. It then issues the clear while the indices are still unequal. The status must read 0 right after that edge and 1 one edge later. The bench also drives an increment at the last entry, where the wrap and the cycle toggle must land in the same edge, and checks both through the read port and the merged address.

// File: rtl/post_list_tracker.sv
module post_list_tracker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 11,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [ADDR_W-1:0] frame_addr,
  output logic [ADDR_W-1:0] xmfa_out,
  output logic              irq
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_PROD = 3'd1;
  localparam logic [2:0] A_INCR = 3'd2;
  localparam logic [2:0] A_CONS = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  logic              en_q;
  logic [CODE_W-1:0] code_q;
  logic [IDX_W-1:0]  prod_q, cons_q;
  logic              cyc_q, stat_q;

  logic [CODE_W:0]   shamt;
  logic [IDX_W:0]    span;
  logic [IDX_W-1:0]  last;
  logic              wr_ctrl, wr_prod, wr_incr, wr_cons, wr_clr, at_end;

  assign shamt   = {1'b0, code_q} + (CODE_W+1)'(4);
  assign span    = (IDX_W+1)'(1) << shamt;
  assign last    = IDX_W'(span - (IDX_W+1)'(1));
  assign at_end  = prod_q >= last;

  assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
  assign wr_prod = reg_wr && reg_addr == A_PROD;
  assign wr_incr = reg_wr && reg_addr == A_INCR;
  assign wr_cons = reg_wr && reg_addr == A_CONS;
  assign wr_clr  = reg_wr && reg_addr == A_STAT && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= '0;
    end else if (wr_ctrl) begin
      en_q   <= reg_wdata[0];
      code_q <= reg_wdata[4 +: CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      cyc_q  <= 1'b1;
    end else if (wr_prod) begin
      prod_q <= reg_wdata[IDX_W-1:0] & last;
      cyc_q  <= 1'b1;
    end else if (wr_incr) begin
      if (at_end) begin
        prod_q <= '0;
        cyc_q  <= ~cyc_q;
      end else begin
        prod_q <= prod_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cons_q <= '0;
    else if (wr_cons) cons_q <= reg_wdata[IDX_W-1:0] & last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stat_q <= 1'b0;
    else if (wr_clr) stat_q <= 1'b0;
    else             stat_q <= stat_q | (en_q && prod_q != cons_q);
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {{(28-CODE_W){1'b0}}, code_q, 3'b000, en_q};
      A_PROD:  reg_rdata = {cyc_q, {(31-IDX_W){1'b0}}, prod_q};
      A_CONS:  reg_rdata = {{(32-IDX_W){1'b0}}, cons_q};
      A_STAT:  reg_rdata = {31'b0, stat_q};
      default: reg_rdata = 32'b0;
    endcase
  end

  assign xmfa_out = {frame_addr[ADDR_W-1:4], 3'b000, cyc_q};
  assign irq      = stat_q;

  logic unused_bits;
  assign unused_bits = ^{frame_addr[3:0], reg_wdata[31:IDX_W]};
endmodule

module post_list_tracker_chk #(
  parameter int IDX_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr,
  input logic [2:0]       addr,
  input logic [31:0]      wdata,
  input logic [IDX_W-1:0] prod,
  input logic [IDX_W-1:0] cons,
  input logic [IDX_W-1:0] last,
  input logic             cyc,
  input logic             en,
  input logic             stat
);
  logic inc, ld, cw, clr;
  assign inc = wr && addr == 3'd2;
  assign ld  = wr && addr == 3'd1;
  assign cw  = wr && addr == 3'd3;
  assign clr = wr && addr == 3'd4 && wdata[0];

  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && prod < last) |=> (prod == $past(prod) + IDX_W'(1)) && (cyc == $past(cyc)));

  a_r5_wrap_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && prod >= last) |=> (prod == '0) && (cyc != $past(cyc)));

  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cyc && (prod == ($past(wdata[IDX_W-1:0]) & $past(last))));

  a_r7_cons_keeps_prod: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> prod == $past(prod));

  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en && prod != cons && !clr) |=> stat);

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !stat);

  a_r10_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !stat) |=> !stat);
endmodule

bind post_list_tracker post_list_tracker_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
  .prod(prod_q), .cons(cons_q), .last(last), .cyc(cyc_q), .en(en_q), .stat(stat_q)
);

// File: tb/tb_post_list_tracker.sv
`timescale 1ns/1ps
module tb_post_list_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [31:0] frame_addr = 32'd0;
  logic [31:0] xmfa_out;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  post_list_tracker dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_addr(frame_addr),
    .xmfa_out(xmfa_out), .irq(irq)
  );

  // {write address, write data, expected register 1 afterwards}
  localparam logic [66:0] VEC [11] = '{
    {3'd0, 32'h0000_0001, 32'h8000_0000},
    {3'd2, 32'hFFFF_FFFF, 32'h8000_0001},
    {3'd1, 32'h0000_000E, 32'h8000_000E},
    {3'd2, 32'h0000_0000, 32'h8000_000F},
    {3'd2, 32'h0000_0000, 32'h0000_0000},
    {3'd2, 32'h0000_0000, 32'h0000_0001},
    {3'd1, 32'h0000_0025, 32'h8000_0005},
    {3'd0, 32'h0000_0011, 32'h8000_0005},
    {3'd1, 32'h0000_001F, 32'h8000_001F},
    {3'd2, 32'h0000_0000, 32'h0000_0000},
    {3'd3, 32'h0000_0007, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 32'h0);
    rd(3'd1, v); check("R1 producer/cycle", v, 32'h8000_0000);
    rd(3'd3, v); check("R1 consumer", v, 32'h0);
    rd(3'd4, v); check("R1 status", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    frame_addr = 32'h1234_5678;
    #0.1 check("R2 xmfa cycle 1", xmfa_out, 32'h1234_5671);

    // vector walk: R3 R4 R5 R6 R7
    foreach (VEC[i]) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rd(3'd1, v);
      check($sformatf("R4/R5/R6/R7 vector %0d", i), v, VEC[i][31:0]);
    end
    rd(3'd0, v); check("R3 ctrl readback", v, 32'h0000_0011);
    rd(3'd3, v); check("R7 consumer readback", v, 32'h0000_0007);
    rd(3'd2, v); check("R7 incr reads zero", v, 32'h0);
    frame_addr = 32'hABCD_EF0F;
    #0.1 check("R2 xmfa cycle 0", xmfa_out, 32'hABCD_EF00);

    // R10 disabled: no status even with unequal indices
    do_reset();
    wr(3'd2, 32'h0);
    @(negedge clk); @(negedge clk);
    check("R10 disabled no irq", {31'b0, irq}, 32'h0);

    // R8 set one edge after enable
    wr(3'd0, 32'h0000_0001);
    check("R8 not yet set", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 set", {31'b0, irq}, 32'h1);
    wr(3'd3, 32'h0000_0001);
    @(negedge clk); @(negedge clk);
    check("R8 sticky when equal", {31'b0, irq}, 32'h1);

    // R9 write-one-to-clear
    wr(3'd4, 32'h0000_0000);
    check("R9 zero write no effect", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h0000_0001);
    @(negedge clk);
    rd(3'd4, v); check("R9 cleared", v, 32'h0);
    wr(3'd2, 32'h0);
    @(negedge clk);
    check("R9 set before race", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h0000_0001);
    check("R9 clear wins", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9 sets again", {31'b0, irq}, 32'h1);

    // R3 R5 largest list: 2048 entries
    wr(3'd0, 32'h0000_0071);
    rd(3'd0, v); check("R3 code 7 readback", v, 32'h0000_0071);
    wr(3'd1, 32'h0000_07FF);
    rd(3'd1, v); check("R6 load 2047", v, 32'h8000_07FF);
    wr(3'd2, 32'h0);
    rd(3'd1, v); check("R5 wrap at 2048", v, 32'h0000_0000);
    wr(3'd2, 32'h0);
    rd(3'd1, v); check("R4 advance after wrap", v, 32'h0000_0001);

    finish_run();
  end
endmodule